// File: doc/BRIEF.md
# I2C Target Clock-Stretch Controller

This block decides when an I2C target holds the SCL line low to stall the bus controller. A bit engine decodes the bus and reports three kinds of event: an ACK/NACK cycle has ended, the controller wants the next transmit byte, and a STOP or bus reset has happened. The receive and transmit buffers report how many received bytes are still unread and whether the transmit buffer is empty. From these inputs the block produces one SCL pull-low enable and one interrupt request.

Stretching comes from three sources, and the pull-low enable is their OR. Automatic stretching is always active and cannot be turned off. On receive it triggers on buffer fill: two unread bytes in plain mode, seventeen in buffered mode. On transmit it triggers on an empty transmit buffer. Extended stretching, when enabled, holds SCL after every ACK/NACK cycle and raises an interrupt, and both stay until software writes a one-cycle release strobe. Manual stretching, when enabled, holds SCL after ACK/NACK cycles until software clears its enable. The block only begins to pull SCL low while the line is already low, so it never shortens a high phase.

Top module: `i2c_stretch_ctl`

## Requirements
- R1: The cycle after a synchronous reset (`rst_n` low), `scl_hold` and `irq` are both 0.
- R2: With `role_tx`=0 and `fifo_mode`=0, `scl_hold` rises at the clock edge after `rx_count` >= 2 is seen together with a low SCL. It falls at the edge after `rx_count` drops below 2 is seen.
- R3: With `role_tx`=0 and `fifo_mode`=1, the receive threshold is 17. Counts of 2 to 16 cause no stretch.
- R4: With `role_tx`=1, an `ev_tx_req` pulse while `tx_empty`=1 marks a pending transmit stall. `scl_hold` rises one edge after the mark is stored and stays high until `tx_empty` goes to 0. It falls at the edge after that.
- R5: Automatic stretching (R2 to R4) works with `ext_en`=0 and `man_en`=0. It has no disable input.
- R6: With `ext_en`=1, an `ev_ack` pulse sets `irq` at the next edge and `scl_hold` one edge later. Both stay until an `sw_release` pulse. `irq` clears at that edge and `scl_hold` clears at the edge after it.
- R7: `irq` is a level. Once set it stays at 1 until `sw_release` or a clear, even if `ext_en` is dropped.
- R8: With `man_en`=1, an `ev_ack` pulse leads to `scl_hold`=1 two edges later. It stays until `man_en` is 0, and `scl_hold` falls one edge after the stored state clears.
- R9: `scl_hold` can rise only at an edge where `scl_in` was sampled low. Once high, it does not depend on `scl_in`.
- R10: A `bus_clr` pulse clears all stretch state and `irq`. At the next edge `scl_hold`=0 and `irq`=0, and this wins over any event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_clr | input | 1 | STOP or bus reset seen, one-cycle pulse |
| scl_in | input | 1 | Sampled SCL level, 1 = high |
| role_tx | input | 1 | 1 = target transmitter, 0 = target receiver |
| fifo_mode | input | 1 | 1 = buffered receive (threshold 17), 0 = plain (threshold 2) |
| ext_en | input | 1 | Extended stretch enable |
| man_en | input | 1 | Manual stretch enable |
| rx_count | input | CW | Received bytes not yet read |
| tx_empty | input | 1 | Transmit buffer holds no byte |
| ev_ack | input | 1 | ACK/NACK cycle finished, pulse |
| ev_tx_req | input | 1 | Controller requests next transmit byte, pulse |
| sw_release | input | 1 | Software release strobe, one cycle |
| scl_hold | output | 1 | Pull SCL low |
| irq | output | 1 | Interrupt request level |

## Verification
The bench targets the two threshold edges in each receive mode: a count of 1 against 2, and 16 against 17. A wrong comparison or a swapped mode select would stretch one byte early or one byte late. It checks that a stretch never starts while SCL is high; a design without that gate would pull the line low in mid-phase. It checks that `irq` survives the extended enable being dropped and clears only on the release strobe; a design that derived `irq` from the enable would lose it. It checks that a bus clear beats a coincident ACK event; a design giving the event priority would stay stretched after STOP.

// File: rtl/i2c_stretch_ctl.sv
module i2c_stretch_ctl #(
  parameter int CW = 5,
  parameter int RX_THR_PLAIN = 2,
  parameter int RX_THR_FIFO = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_clr,
  input  logic          scl_in,
  input  logic          role_tx,
  input  logic          fifo_mode,
  input  logic          ext_en,
  input  logic          man_en,
  input  logic [CW-1:0] rx_count,
  input  logic          tx_empty,
  input  logic          ev_ack,
  input  logic          ev_tx_req,
  input  logic          sw_release,
  output logic          scl_hold,
  output logic          irq
);
  localparam logic [CW-1:0] THR_P = CW'(RX_THR_PLAIN);
  localparam logic [CW-1:0] THR_F = CW'(RX_THR_FIFO);

  logic tx_wait, ext_wait, man_wait;
  logic rx_full, want, clr;

  assign clr     = !rst_n || bus_clr;
  assign rx_full = !role_tx && (rx_count >= (fifo_mode ? THR_F : THR_P));
  assign want    = rx_full || (tx_wait && tx_empty) || ext_wait || man_wait;

  always_ff @(posedge clk) begin
    if (clr) begin
      tx_wait  <= 1'b0;
      ext_wait <= 1'b0;
      man_wait <= 1'b0;
      irq      <= 1'b0;
      scl_hold <= 1'b0;
    end else begin
      tx_wait  <= role_tx && tx_empty && (tx_wait || ev_tx_req);
      ext_wait <= (ext_wait && !sw_release) || (ext_en && ev_ack);
      man_wait <= man_en && (man_wait || ev_ack);
      irq      <= (irq && !sw_release) || (ext_en && ev_ack);
      scl_hold <= want && (scl_hold || !scl_in);
    end
  end
endmodule

module i2c_stretch_ctl_chk #(
  parameter int CW = 5,
  parameter int RX_THR_PLAIN = 2,
  parameter int RX_THR_FIFO = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_clr,
  input logic          scl_in,
  input logic          role_tx,
  input logic          fifo_mode,
  input logic          ext_en,
  input logic [CW-1:0] rx_count,
  input logic          ev_ack,
  input logic          sw_release,
  input logic          scl_hold,
  input logic          irq
);
  localparam int THR_P = RX_THR_PLAIN;
  localparam int THR_F = RX_THR_FIFO;

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    bus_clr |=> (!scl_hold && !irq));

  a_r9_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hold && !$past(scl_hold) && $past(rst_n)) |-> !$past(scl_in));

  a_r7_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !sw_release && !bus_clr) |=> irq);

  a_r6_ext_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_en && ev_ack && !bus_clr) |=> irq);

  a_r2_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!role_tx && !bus_clr && (!scl_in || scl_hold) &&
     (int'(rx_count) >= (fifo_mode ? THR_F : THR_P))) |=> scl_hold);
endmodule

bind i2c_stretch_ctl i2c_stretch_ctl_chk #(
  .CW(CW), .RX_THR_PLAIN(RX_THR_PLAIN), .RX_THR_FIFO(RX_THR_FIFO)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_clr(bus_clr), .scl_in(scl_in),
  .role_tx(role_tx), .fifo_mode(fifo_mode), .ext_en(ext_en),
  .rx_count(rx_count), .ev_ack(ev_ack), .sw_release(sw_release),
  .scl_hold(scl_hold), .irq(irq)
);

// File: tb/i2c_stretch_ctl_tb.sv
`timescale 1ns/1ps
module i2c_stretch_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0, bus_clr = 1'b0, scl_drv = 1'b1, role_tx = 1'b0;
  logic fifo_mode = 1'b0, ext_en = 1'b0, man_en = 1'b0, tx_empty = 1'b0;
  logic ev_ack = 1'b0, ev_tx_req = 1'b0, sw_release = 1'b0;
  logic [4:0] rx_count = '0;
  logic scl_in, scl_hold, irq;
  int total = 0, bad = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #5 clk = ~clk;
  assign scl_in = scl_drv & ~scl_hold;

  i2c_stretch_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_clr(bus_clr), .scl_in(scl_in),
    .role_tx(role_tx), .fifo_mode(fifo_mode), .ext_en(ext_en), .man_en(man_en),
    .rx_count(rx_count), .tx_empty(tx_empty), .ev_ack(ev_ack),
    .ev_tx_req(ev_tx_req), .sw_release(sw_release),
    .scl_hold(scl_hold), .irq(irq));

  bit m_tx, m_ext, m_man, m_irq, m_hold;
  always @(posedge clk) begin
    if (!rst_n || bus_clr) begin
      m_tx = 0; m_ext = 0; m_man = 0; m_irq = 0; m_hold = 0;
    end else begin
      int thr;
      bit want, n_tx, n_ext, n_man, n_irq;
      thr  = fifo_mode ? 17 : 2;
      want = (!role_tx && int'(rx_count) >= thr) || (m_tx && tx_empty) || m_ext || m_man;
      n_tx = role_tx && tx_empty && (m_tx || ev_tx_req);
      n_ext = ext_en && ev_ack ? 1'b1 : (sw_release ? 1'b0 : m_ext);
      n_irq = ext_en && ev_ack ? 1'b1 : (sw_release ? 1'b0 : m_irq);
      n_man = man_en ? (m_man || ev_ack) : 1'b0;
      m_hold = want && (m_hold || !scl_in);
      m_tx = n_tx; m_ext = n_ext; m_irq = n_irq; m_man = n_man;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    total++;
    if (scl_hold !== m_hold || irq !== m_irq) begin
      bad++;
      $display("FAIL %s model: hold=%b irq=%b expected hold=%b irq=%b",
               tag, scl_hold, irq, m_hold, m_irq);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic pulse_ack();
    ev_ack = 1'b1; step(1); ev_ack = 1'b0;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    tag = "R1";
    chk("R1 hold after reset", scl_hold, 1'b0);
    chk("R1 irq after reset", irq, 1'b0);

    tag = "R2";
    rx_count = 5'd2; scl_drv = 1'b1; step(2);
    chk("R9 no start while SCL high", scl_hold, 1'b0);
    scl_drv = 1'b0; step(1);
    chk("R2 stretch at 2 bytes", scl_hold, 1'b1);
    scl_drv = 1'b1; step(2);
    chk("R9 hold kept when SCL released by controller", scl_hold, 1'b1);
    rx_count = 5'd1; step(1);
    chk("R2 release below threshold", scl_hold, 1'b0);

    tag = "R3";
    fifo_mode = 1'b1; scl_drv = 1'b0; rx_count = 5'd2; step(2);
    chk("R3 no stretch at 2 in buffered mode", scl_hold, 1'b0);
    rx_count = 5'd16; step(2);
    chk("R3 no stretch at 16", scl_hold, 1'b0);
    rx_count = 5'd17; step(1);
    chk("R3 stretch at 17", scl_hold, 1'b1);
    rx_count = 5'd16; step(1);
    chk("R3 release at 16", scl_hold, 1'b0);
    rx_count = 5'd0; fifo_mode = 1'b0;

    tag = "R4";
    role_tx = 1'b1; tx_empty = 1'b1;
    ev_tx_req = 1'b1; step(1); ev_tx_req = 1'b0;
    step(1);
    chk("R5 R4 tx stretch with all enables off", scl_hold, 1'b1);
    step(3);
    chk("R4 tx stretch held", scl_hold, 1'b1);
    tx_empty = 1'b0; step(1);
    chk("R4 release when data arrives", scl_hold, 1'b0);
    role_tx = 1'b0;

    tag = "R6";
    ext_en = 1'b1; pulse_ack();
    chk("R6 irq raised", irq, 1'b1);
    step(1);
    chk("R6 ext stretch", scl_hold, 1'b1);
    step(4);
    chk("R6 ext stretch held without release", scl_hold, 1'b1);
    sw_release = 1'b1; step(1); sw_release = 1'b0;
    chk("R6 irq cleared by release", irq, 1'b0);
    step(1);
    chk("R6 stretch released", scl_hold, 1'b0);

    tag = "R7";
    pulse_ack();
    ext_en = 1'b0; step(3);
    chk("R7 irq stays after enable drop", irq, 1'b1);
    sw_release = 1'b1; step(1); sw_release = 1'b0;
    chk("R7 irq cleared", irq, 1'b0);
    step(1);

    tag = "R8";
    man_en = 1'b1; pulse_ack(); step(1);
    chk("R8 manual stretch", scl_hold, 1'b1);
    step(3);
    chk("R8 manual held", scl_hold, 1'b1);
    man_en = 1'b0; step(2);
    chk("R8 release on enable clear", scl_hold, 1'b0);

    tag = "R10";
    ext_en = 1'b1; man_en = 1'b1; pulse_ack(); step(1);
    chk("R10 stretched before clear", scl_hold, 1'b1);
    bus_clr = 1'b1; ev_ack = 1'b1; step(1); bus_clr = 1'b0; ev_ack = 1'b0;
    chk("R10 hold cleared", scl_hold, 1'b0);
    chk("R10 irq cleared", irq, 1'b0);
    man_en = 1'b0; ext_en = 1'b0; step(3);
    chk("R10 stays released", scl_hold, 1'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule